// File: doc/BRIEF.md
# Modem Line Change Monitor

This block watches four active-low modem control inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them to a host as one 8-bit read-only status byte. Each input first passes through a two-flop synchroniser. The upper nibble of the byte shows the present synchronised level of each line, inverted so that an asserted line reads as 1. The lower nibble holds sticky change flags that record activity since the host last read the byte.

Three of the change flags latch on any transition of their line. The ring-indicator flag is different: it latches only when the ring input pin returns from low to high, which marks the end of a ring burst. A read strobe clears all four flags at the clock edge where it is sampled. A transition seen in that same cycle still sets its flag, so no change is lost.

An interrupt request output is high while at least one flag is set and the modem-status interrupt enable input is 1. It falls in the same cycle that either condition goes away.

Top module: `modem_delta_mon`

## Requirements
- R1: Status bits 7:4 show the inverted synchronised levels of the carrier-detect, ring, data-set-ready and clear-to-send pins (bit 7 = carrier detect, bit 4 = clear-to-send). A pin change becomes visible there SYNC_STAGES clock edges after it is applied.
- R2: Bit 0 sets on any level change of the clear-to-send input, one clock edge after the change appears in bit 4.
- R3: Bit 1 sets on any level change of the data-set-ready input, one clock edge after the change appears in bit 5.
- R4: Bit 2 sets only when the ring pin goes from low to high, so that bit 6 falls from 1 to 0. A high-to-low transition of the ring pin leaves bit 2 unchanged.
- R5: Bit 3 sets on any level change of the carrier-detect input, one clock edge after the change appears in bit 7.
- R6: While reset is asserted, and right after it, bits 3:0 are 0 and the interrupt request is low. With all pins high, bits 7:4 are also 0.
- R7: A clock edge that samples the read strobe high clears bits 3:0 when no change is detected in that cycle. Bits 7:4 are not affected by the read.
- R8: A set change flag stays set until a read clears it.
- R9: A change detected in the same cycle as the read strobe leaves its flag set after that edge.
- R10: The interrupt request equals (enable AND any of bits 3:0). It is combinational, so it drops in the same cycle that the flags clear or the enable goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| rd_stb | input | 1 | Status read strobe; clears the change flags |
| ie_msr | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Levels in bits 7:4, change flags in bits 3:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It uses that value to place every sample exactly at the edge where a level or a flag should first appear. With this depth it can show that a level is not yet visible one edge after a pin change and is visible on the next. It can also line up a detected change with a read strobe in the same cycle. The vector walk drives the ring pin in both directions, so the one-directional ring flag can be told apart from the any-edge flags.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int LINES = 4;
    typedef enum int {
        LN_CTS = 0,
        LN_DSR = 1,
        LN_RI  = 2,
        LN_CD  = 3
    } line_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: {STAGES{RST_VAL}}};
        else        s_q <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
    parameter bit ANY_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic clr,
    output logic level,
    output logic flag
);
    typedef struct packed {
        logic prev;
        logic flag;
    } delta_t;

    delta_t d_d, d_q;
    logic   hit;

    // Any-edge lines compare against the previous value; the ring line
    // only reacts to the pin returning high.
    generate
        if (ANY_EDGE) begin : g_any
            assign hit = pin_s ^ d_q.prev;
        end else begin : g_rise
            assign hit = pin_s & ~d_q.prev;
        end
    endgenerate

    always_comb begin
        d_d      = d_q;
        d_d.prev = pin_s;
        d_d.flag = hit | (d_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '{prev: 1'b1, flag: 1'b0};
        else        d_q <= d_d;
    end

    assign level = ~pin_s;
    assign flag  = d_q.flag;
endmodule

// File: rtl/modem_delta_mon.sv
module modem_delta_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       cd_n,
    input  logic       rd_stb,
    input  logic       ie_msr,
    output logic [7:0] status,
    output logic       irq
);
    import msr_pkg::*;

    logic [LINES-1:0] pins_n;
    logic [LINES-1:0] pins_s;
    logic [LINES-1:0] levels;
    logic [LINES-1:0] flags;

    assign pins_n = {cd_n, ri_n, dsr_n, cts_n};

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            msr_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (pins_n[i]),
                .dout  (pins_s[i])
            );

            msr_delta #(
                .ANY_EDGE (i != int'(LN_RI))
            ) u_delta (
                .clk   (clk),
                .rst_n (rst_n),
                .pin_s (pins_s[i]),
                .clr   (rd_stb),
                .level (levels[i]),
                .flag  (flags[i])
            );
        end
    endgenerate

    assign status = {levels, flags};
    assign irq    = ie_msr & (|flags);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       ie_msr,
    input logic [7:0] status,
    input logic       irq
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (status[3:0] == 4'h0)); // R6
    AST_CTS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !$stable(status[4]) |=> status[0]); // R2
    AST_DSR_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !$stable(status[5]) |=> status[1]); // R3
    AST_CD_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !$stable(status[7]) |=> status[3]); // R5
    AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[2]) |-> ($past(status[6], 2) && !$past(status[6]))); // R4
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && $stable(status[7:4])) |=> (status[3:0] == 4'h0)); // R7
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_stb |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0]))); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !ie_msr |-> !irq); // R10
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n) (status[3:0] == 4'h0) |-> !irq); // R10
endmodule

bind modem_delta_mon msr_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .ie_msr (ie_msr),
    .status (status),
    .irq    (irq)
);

// File: tb/sim_modem_delta_mon.sv
module sim_modem_delta_mon;
    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic       rd_stb = 1'b0, ie_msr = 1'b0;
    logic [7:0] status;
    logic       irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    modem_delta_mon #(.SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .cd_n(cd_n), .rd_stb(rd_stb), .ie_msr(ie_msr), .status(status), .irq(irq)
    );

    // pins = {cd_n, ri_n, dsr_n, cts_n}; exp = status after STG+1 edges, before the read
    typedef struct packed {
        logic [3:0] pins;
        logic       ie;
        logic       rd;
        logic [7:0] exp;
        logic       irq;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'b1110, 1'b1, 1'b0, 8'h11, 1'b1, 4'd2},  // R2 clear-to-send asserted
        '{4'b1110, 1'b0, 1'b1, 8'h11, 1'b0, 4'd8},  // R8 flag held, R10 gated off
        '{4'b1100, 1'b1, 1'b0, 8'h32, 1'b1, 4'd3},  // R3 data-set-ready asserted
        '{4'b1000, 1'b1, 1'b1, 8'h72, 1'b1, 4'd4},  // R4 ring start sets nothing
        '{4'b1100, 1'b1, 1'b1, 8'h34, 1'b1, 4'd4},  // R4 ring end sets bit 2
        '{4'b0100, 1'b0, 1'b0, 8'hB8, 1'b0, 4'd5},  // R5 carrier detect asserted
        '{4'b1111, 1'b1, 1'b1, 8'h0B, 1'b1, 4'd1},  // R1 all released, flags gather
        '{4'b1111, 1'b1, 1'b0, 8'h00, 1'b0, 4'd7}   // R7 cleared after read
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 status after reset", status, 8'h00);
        chk("R6 irq after reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        edges(2);
        chk("R6 status after release", status, 8'h00);

        for (int v = 0; v < 8; v++) begin
            {cd_n, ri_n, dsr_n, cts_n} = VECS[v].pins;
            ie_msr = VECS[v].ie;
            edges(STG + 1);
            chk($sformatf("R%0d vector %0d status", VECS[v].req, v), status, VECS[v].exp);
            chk($sformatf("R10 vector %0d irq", v), {7'b0, irq}, {7'b0, VECS[v].irq});
            if (VECS[v].rd) begin
                rd_stb = 1'b1;
                edges(1);
                rd_stb = 1'b0;
                chk($sformatf("R7 vector %0d after read", v), status, {VECS[v].exp[7:4], 4'h0});
                chk($sformatf("R10 vector %0d irq after read", v), {7'b0, irq}, 8'h00);
            end
        end

        // R1 latency: not visible one edge early, visible at STG edges
        ie_msr = 1'b1;
        cts_n = 1'b0;
        edges(STG - 1);
        chk("R1 level one edge early", status, 8'h00);
        edges(1);
        chk("R1 level at sync depth", status, 8'h10);
        edges(1);
        chk("R2 flag one edge later", status, 8'h11);
        rd_stb = 1'b1;
        edges(1);
        rd_stb = 1'b0;
        chk("R7 read clears", status, 8'h10);

        // R9: change detected in the same cycle as the read
        cts_n = 1'b1;
        edges(STG);
        rd_stb = 1'b1;
        edges(1);
        rd_stb = 1'b0;
        chk("R9 change during read kept", status, 8'h01);
        chk("R10 irq with kept flag", {7'b0, irq}, 8'h01);
        edges(10);
        chk("R8 flag still held", status, 8'h01);
        ie_msr = 1'b0;
        #1;
        chk("R10 irq drops with enable", {7'b0, irq}, 8'h00);

        // R4: ring start alone leaves bit 2 clear
        rd_stb = 1'b1;
        edges(1);
        rd_stb = 1'b0;
        ri_n = 1'b0;
        edges(STG + 3);
        chk("R4 ring start no flag", status, 8'h40);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule